// File: doc/BRIEF.md
# Level-1 latency pipeline buffer

This block holds detector samples while the first-level trigger decides which bunch crossings to keep. On every crossing clock one sample enters a circular buffer of fixed depth, so the buffer always holds the most recent DEPTH crossings. A keep/drop decision arrives for every crossing after a fixed, programmable latency. When the decision says keep, the sample taken that many cycles earlier is copied from the buffer into a small derandomizing queue. The copy carries the crossing number of that sample. Samples that are never selected are overwritten when the write pointer comes round again.

The downstream reader empties the queue through a valid/ready pair. When the queue is full the block raises busy so that the trigger source can hold back further decisions. A decision that still arrives while the queue is full is discarded, and a saturating counter records it. The crossing tag is not stored in the buffer. It is derived from a free-running crossing counter minus the programmed latency.

Top module: `l1_latency_pipe`

## Requirements
- R1: On every clock after reset, `sample_in` is written into a ring of DEPTH entries, and the write position advances by one per cycle.
- R2: `accept` high in the cycle of crossing c copies the sample written at crossing c−`lat` into the queue. `lat` is valid from 1 to DEPTH−1.
- R3: `rd_bx` carries the crossing number of the sample. Crossings are counted from 0 at the first clock after reset and wrap modulo 2^BXID_W.
- R4: Only selected samples appear at the read port. With no `accept`, `rd_valid` stays low.
- R5: Queued entries leave in the order they were accepted. While `rd_valid` is high and `rd_ready` is low, the output word and `rd_valid` hold.
- R6: `busy` is high exactly when the queue holds FIFO_DEPTH entries. FIFO_DEPTH is a power of two.
- R7: An `accept` while `busy` is high is dropped, even if a read occurs in the same cycle. The drop increments `overflow_cnt` by one, and the count saturates at all ones.
- R8: Synchronous reset empties the queue, clears `overflow_cnt` and restarts the crossing count. After reset, `rd_valid`, `busy` and `overflow_cnt` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| lat | input | LAT_W | Trigger latency in crossings |
| sample_in | input | DATA_W | Detector sample of the current crossing |
| accept | input | 1 | Keep decision for crossing current−lat |
| rd_sample | output | DATA_W | Sample at the head of the queue |
| rd_bx | output | BXID_W | Crossing number of the head sample |
| rd_valid | output | 1 | Queue not empty |
| rd_ready | input | 1 | Reader takes the head word |
| busy | output | 1 | Queue full |
| overflow_cnt | output | OVF_W | Saturating count of dropped accepts |

## Verification
The delicate coincidence is a keep decision that arrives while the queue is full, in the same cycle as a read. The read frees a slot at that very edge, but the decision must still be dropped and counted. The bench fills the queue with a burst of accepts, then drives `accept` and `rd_ready` together. It then checks that `overflow_cnt` went up by one, that `busy` fell, and that draining returns exactly the earlier accepted crossings in order. A second coincidence, where the write pointer wraps under a one-cycle latency, is covered by table entries with latency 1 and DEPTH−1.

// File: rtl/l1_latency_pipe.sv
module l1_latency_pipe #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 128,
  parameter int BXID_W     = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int OVF_W      = 8,
  parameter int LAT_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              accept,
  output logic [DATA_W-1:0] rd_sample,
  output logic [BXID_W-1:0] rd_bx,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic [OVF_W-1:0]  overflow_cnt
);
  localparam int FAW = $clog2(FIFO_DEPTH);
  localparam logic [FAW:0] FCAP = FAW'(0) + (FAW+1)'(FIFO_DEPTH);

  logic [DATA_W-1:0] ring [DEPTH];
  logic [LAT_W-1:0]  wp;
  logic [BXID_W-1:0] bx;
  wire  [LAT_W-1:0]  rp = wp - lat;

  logic [DATA_W+BXID_W-1:0] fq [FIFO_DEPTH];
  logic [FAW-1:0] fh, ft;
  logic [FAW:0]   fc;

  assign busy     = (fc == FCAP);
  assign rd_valid = (fc != '0);
  wire push = accept && !busy;
  wire pop  = rd_valid && rd_ready;
  assign {rd_bx, rd_sample} = fq[fh];

  always_ff @(posedge clk) ring[wp] <= sample_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      bx <= '0;
    end else begin
      wp <= wp + 1'b1;
      bx <= bx + 1'b1;
    end
  end

  always_ff @(posedge clk) if (push) fq[ft] <= {bx - BXID_W'(lat), ring[rp]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fh <= '0;
      ft <= '0;
      fc <= '0;
      overflow_cnt <= '0;
    end else begin
      if (push) ft <= ft + 1'b1;
      if (pop)  fh <= fh + 1'b1;
      fc <= fc + (FAW+1)'(push) - (FAW+1)'(pop);
      if (accept && busy && overflow_cnt != '1) overflow_cnt <= overflow_cnt + 1'b1;
    end
  end

  assert_wp_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wp == $past(wp) + 1'b1);
  assert_push_visible_R2: assert property (@(posedge clk) disable iff (rst)
    accept && !busy |=> rd_valid);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_sample) && $stable(rd_bx));
  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (rst)
    fc <= FCAP);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    accept && busy && overflow_cnt != '1 |=> overflow_cnt == $past(overflow_cnt) + 1'b1);
endmodule

// File: tb/tb_l1_latency_pipe.sv
`timescale 1ns/1ps
module tb_l1_latency_pipe;
  logic clk = 0, rst = 1, accept = 0, rd_ready = 0;
  logic [6:0] lat = 7'd1;
  logic [15:0] sample_in = 0, rd_sample;
  logic [11:0] rd_bx;
  logic rd_valid, busy;
  logic [7:0] overflow_cnt;
  int n = 0, checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l1_latency_pipe dut (.clk, .rst, .lat, .sample_in, .accept, .rd_sample, .rd_bx,
    .rd_valid, .rd_ready, .busy, .overflow_cnt);

  function automatic logic [15:0] f(int c); return 16'(c * 37 + 5); endfunction

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic acc, logic rdy);
    sample_in = f(n); accept = acc; rd_ready = rdy;
    @(posedge clk); n++;
    @(negedge clk);
    accept = 0; rd_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; n = 0;
  endtask

  // {latency, offset}: accept at crossing lat+offset selects crossing offset
  localparam logic [15:0] VEC [8] = '{
    {8'd1, 8'd0}, {8'd1, 8'd5}, {8'd127, 8'd0}, {8'd127, 8'd3},
    {8'd64, 8'd10}, {8'd10, 8'd200}, {8'd33, 8'd1}, {8'd100, 8'd50}};

  initial begin
    do_reset();
    cmp("R8 rd_valid", rd_valid, 0);
    cmp("R8 busy", busy, 0);
    cmp("R8 overflow_cnt", overflow_cnt, 0);
    repeat (20) step(0, 1);
    cmp("R4 nothing queued", rd_valid, 0);

    for (int i = 0; i < 8; i++) begin
      int l = VEC[i][15:8], off = VEC[i][7:0];
      do_reset();
      lat = 7'(l);
      while (n < l + off) step(0, 0);
      step(1, 0);
      cmp("R2 valid", rd_valid, 1);
      cmp("R2 sample", rd_sample, f(off));
      cmp("R3 bx", rd_bx, off);
      step(0, 1);
      cmp("R4 drained", rd_valid, 0);
    end

    do_reset();
    lat = 7'd20;
    while (n < 30) step(0, 0);
    for (int k = 0; k < 10; k++) step(1, 0);
    cmp("R6 busy when full", busy, 1);
    cmp("R7 overflow two", overflow_cnt, 2);
    cmp("R5 head sample", rd_sample, f(10));
    step(1, 1);
    cmp("R7 accept+read while full dropped", overflow_cnt, 3);
    cmp("R6 busy falls", busy, 0);
    for (int k = 11; k < 18; k++) begin
      cmp("R5 order sample", rd_sample, f(k));
      cmp("R5 order bx", rd_bx, k);
      step(0, 1);
    end
    cmp("R4 empty after drain", rd_valid, 0);

    while (n < 60) step(0, 0);
    for (int k = 0; k < 8; k++) step(1, 0);
    for (int k = 0; k < 300; k++) step(1, 0);
    cmp("R7 saturate", overflow_cnt, 255);
    cmp("R5 hold head", rd_sample, f(40));

    do_reset();
    lat = 7'd5;
    while (n < 4096 + 5) step(0, 0);
    step(1, 0);
    step(1, 0);
    cmp("R3 wrap sample", rd_sample, f(4096));
    cmp("R3 wrap bx", rd_bx, 0);
    step(0, 1);
    cmp("R3 next bx", rd_bx, 1);
    cmp("R1 ring sample", rd_sample, f(4097));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule